// File: doc/BRIEF.md
# 8b/10b Line Encoder with Two-Symbol Mode and Disparity Override

This block turns byte-wide symbols into 10-bit DC-balanced code groups for a serial transmit path. Each symbol is an 8-bit value plus a flag that marks it as a control character. The block follows the Clause 36 5b/6b and 3b/4b tables and keeps a running disparity from one symbol to the next. It is built with one lane, which takes one symbol per clock, or with two lanes, which take two symbols per clock. In the two-lane build the lower symbol is encoded first. The disparity it ends with becomes the starting disparity of the upper symbol in the same cycle.

A qualifying strobe marks the cycles that carry symbols. An override input lets the user replace the stored running disparity at the start of a cycle, for example to line up with a link partner or to build test patterns. A control flag on a byte that is not a legal control character raises a per-lane flag, and that byte is sent as ordinary data. All outputs are registered.

Top module: `lc8b10b_enc`

## Requirements
- R1: A data symbol (control flag low) is encoded by the Clause 36 tables for its starting disparity. The byte is split as x = bits [4:0] and y = bits [7:5]. The output code group carries a in bit 9, then b, c, d, e, i, f, g, h, and j in bit 0. For example, D0.0 with negative disparity gives 10'b1001110100.
- R2: A control symbol is legal for x = 28 with any y, and for y = 7 with x in {23, 27, 29, 30}. It uses the control-character codes. For example, K28.5 gives 10'b0011111010 when the disparity is negative and 10'b1100000101 when it is positive.
- R3: Every code group has 4, 5 or 6 ones. After each symbol the running disparity, shown on rd_o (1 = positive), holds that symbol's ending disparity. A code group with 6 ones leaves it positive, and one with 4 ones leaves it negative.
- R4: After reset, code_o, kerr_o and code_vld_o are all zero and the running disparity is negative.
- R5: A data byte with y = 7 uses the alternate 4-bit code 0111/1000 when the disparity after the 6-bit part is negative and x is 17, 18 or 20. It also does so when that disparity is positive and x is 11, 13 or 14. In every other data case it uses the primary code 1110/0001.
- R6: A control flag on a byte that is not a legal control character sets that lane's kerr_o bit. The byte is then encoded exactly as the data symbol with the same value.
- R7: With two lanes, lane 0 uses data_i[7:0] and ctl_i[0] and drives code_o[9:0]. Lane 1 uses data_i[15:8] and ctl_i[1] and drives code_o[19:10]. Lane 1 starts from the ending disparity of lane 0, and rd_o holds the ending disparity of lane 1.
- R8: When valid_i and force_en_i are both high, force_rd_i (1 = positive) replaces the stored running disparity as the starting disparity of lane 0 in that cycle.
- R9: The code groups and error flags for a valid cycle appear one clock later. code_vld_o is valid_i delayed by one clock.
- R10: In a cycle with valid_i low, code_o, kerr_o and rd_o keep their values, and force_en_i has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| valid_i | input | 1 | Marks a cycle that carries symbols |
| data_i | input | 8*LANES | Symbol bytes, lane 0 in the low byte |
| ctl_i | input | LANES | Control-character flag for each lane |
| force_en_i | input | 1 | Replace the running disparity at the start of this cycle |
| force_rd_i | input | 1 | Disparity to force, 1 = positive |
| code_o | output | 10*LANES | Registered code groups, lane 0 in bits [9:0] |
| code_vld_o | output | 1 | High one clock after a valid cycle |
| kerr_o | output | LANES | Per-lane flag for an illegal control symbol |
| rd_o | output | 1 | Current running disparity, 1 = positive |

## Verification
The bench builds the block twice. The first copy uses LANES = 1 and runs a vector table. In that table each row forces its own starting disparity, so every row covers one table cell independently of the previous row: both disparities of the control characters, the alternate D.x.7 cases, and an illegal control flag. The second copy uses LANES = 2, which brings the disparity hand-off between the lanes within a cycle into reach. On that copy the upper code group depends on what the lower one left behind, and the override and the idle-cycle hold are also exercised.

// File: rtl/lc8b10b_pkg.sv
package lc8b10b_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 10;
  typedef logic [5:0] six_t;
  typedef logic [3:0] four_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/lc_sub6.sv
module lc_sub6
  import lc8b10b_pkg::*;
(
  input  logic [4:0] x_i,
  input  logic       k28_i,
  input  logic       rd_i,
  output six_t       six_o,
  output logic       rd_o
);
  six_t base;
  logic unbal;
  logic flip;

  // 6-bit codes for negative disparity, a in bit 5, i in bit 0
  always_comb begin
    case (x_i)
      5'd0:  base = 6'b100111;
      5'd1:  base = 6'b011101;
      5'd2:  base = 6'b101101;
      5'd3:  base = 6'b110001;
      5'd4:  base = 6'b110101;
      5'd5:  base = 6'b101001;
      5'd6:  base = 6'b011001;
      5'd7:  base = 6'b111000;
      5'd8:  base = 6'b111001;
      5'd9:  base = 6'b100101;
      5'd10: base = 6'b010101;
      5'd11: base = 6'b110100;
      5'd12: base = 6'b001101;
      5'd13: base = 6'b101100;
      5'd14: base = 6'b011100;
      5'd15: base = 6'b010111;
      5'd16: base = 6'b011011;
      5'd17: base = 6'b100011;
      5'd18: base = 6'b010011;
      5'd19: base = 6'b110010;
      5'd20: base = 6'b001011;
      5'd21: base = 6'b101010;
      5'd22: base = 6'b011010;
      5'd23: base = 6'b111010;
      5'd24: base = 6'b110011;
      5'd25: base = 6'b100110;
      5'd26: base = 6'b010110;
      5'd27: base = 6'b110110;
      5'd28: base = 6'b001110;
      5'd29: base = 6'b101110;
      5'd30: base = 6'b011110;
      default: base = 6'b101011;
    endcase
    if (k28_i) base = 6'b001111;
  end

  assign unbal = ($countones(base) != 3);
  // the balanced pattern for x = 7 still alternates with disparity
  assign flip  = rd_i && (unbal || (x_i == 5'd7));
  assign six_o = flip ? ~base : base;
  assign rd_o  = unbal ? ~rd_i : rd_i;
endmodule

// File: rtl/lc_sub4.sv
module lc_sub4
  import lc8b10b_pkg::*;
(
  input  logic [2:0] y_i,
  input  logic       alt_i,
  input  logic       k28_i,
  input  logic       rd_i,
  output four_t      four_o,
  output logic       rd_o
);
  four_t base;
  logic bal;
  logic k_inv;
  logic d_inv;

  // 4-bit codes for negative disparity, f in bit 3, j in bit 0
  always_comb begin
    case (y_i)
      3'd0: base = 4'b1011;
      3'd1: base = 4'b1001;
      3'd2: base = 4'b0101;
      3'd3: base = 4'b1100;
      3'd4: base = 4'b1101;
      3'd5: base = 4'b1010;
      3'd6: base = 4'b0110;
      default: base = alt_i ? 4'b0111 : 4'b1110;
    endcase
  end

  assign bal    = ($countones(base) == 2);
  // control characters on x = 28 swap their balanced patterns when disparity is negative
  assign k_inv  = k28_i && !rd_i && bal && (y_i != 3'd3);
  assign d_inv  = rd_i && (!bal || (y_i == 3'd3));
  assign four_o = (k_inv || d_inv) ? ~base : base;
  assign rd_o   = bal ? rd_i : ~rd_i;
endmodule

// File: rtl/lc_symbol.sv
module lc_symbol
  import lc8b10b_pkg::*;
(
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ctl_i,
  input  logic              rd_i,
  output code_t             code_o,
  output logic              rd_o,
  output logic              kerr_o
);
  logic [4:0] x;
  logic [2:0] y;
  logic       k_legal;
  logic       is_k;
  logic       k28;
  logic       rd_mid;
  logic       alt;
  six_t       six;
  four_t      four;

  assign x = data_i[4:0];
  assign y = data_i[7:5];

  assign k_legal = (x == 5'd28) ||
                   ((y == 3'd7) && ((x == 5'd23) || (x == 5'd27) ||
                                    (x == 5'd29) || (x == 5'd30)));
  assign is_k    = ctl_i && k_legal;
  assign kerr_o  = ctl_i && !k_legal;
  assign k28     = is_k && (x == 5'd28);

  lc_sub6 u_sub6 (
    .x_i   (x),
    .k28_i (k28),
    .rd_i  (rd_i),
    .six_o (six),
    .rd_o  (rd_mid)
  );

  // alternate pattern avoids a run of five equal bits across the sub-block edge
  assign alt = (y == 3'd7) &&
               (is_k ||
                (!rd_mid && ((x == 5'd17) || (x == 5'd18) || (x == 5'd20))) ||
                ( rd_mid && ((x == 5'd11) || (x == 5'd13) || (x == 5'd14))));

  lc_sub4 u_sub4 (
    .y_i    (y),
    .alt_i  (alt),
    .k28_i  (k28),
    .rd_i   (rd_mid),
    .four_o (four),
    .rd_o   (rd_o)
  );

  assign code_o = {six, four};
endmodule

// File: rtl/lc8b10b_enc.sv
module lc8b10b_enc
  import lc8b10b_pkg::*;
#(
  parameter int LANES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic                     valid_i,
  input  logic [LANES*BYTE_W-1:0]  data_i,
  input  logic [LANES-1:0]         ctl_i,
  input  logic                     force_en_i,
  input  logic                     force_rd_i,
  output logic [LANES*CODE_W-1:0]  code_o,
  output logic                     code_vld_o,
  output logic [LANES-1:0]         kerr_o,
  output logic                     rd_o
);
  localparam int CW = LANES * CODE_W;

  // reset: asserted at once, released after SYNC_STAGES clocks
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe <= '0;
    else          rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_pipe[SYNC_STAGES-1];

  logic [CW-1:0]    code_q, code_d, code_n;
  logic [LANES-1:0] kerr_q, kerr_d, kerr_n;
  logic             rd_q, rd_n;
  logic             vld_q;
  logic [LANES:0]   rd_chain;

  assign rd_chain[0] = force_en_i ? force_rd_i : rd_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lc_symbol u_sym (
      .data_i (data_i[g*BYTE_W +: BYTE_W]),
      .ctl_i  (ctl_i[g]),
      .rd_i   (rd_chain[g]),
      .code_o (code_d[g*CODE_W +: CODE_W]),
      .rd_o   (rd_chain[g+1]),
      .kerr_o (kerr_d[g])
    );
  end

  // next state: update only in valid cycles
  always_comb begin
    code_n = code_q;
    kerr_n = kerr_q;
    rd_n   = rd_q;
    if (valid_i) begin
      code_n = code_d;
      kerr_n = kerr_d;
      rd_n   = rd_chain[LANES];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      kerr_q <= '0;
      rd_q   <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      code_q <= code_n;
      kerr_q <= kerr_n;
      rd_q   <= rd_n;
      vld_q  <= valid_i;
    end
  end

  assign code_o     = code_q;
  assign kerr_o     = kerr_q;
  assign rd_o       = rd_q;
  assign code_vld_o = vld_q;

  // checks
  assert_vld_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    valid_i |=> code_vld_o);
  assert_vld_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !valid_i |=> !code_vld_o);
  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !valid_i |=> ($stable(rd_o) && $stable(code_o) && $stable(kerr_o)));

  for (genvar a = 0; a < LANES; a++) begin : g_chk
    assert_ones_range_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
      code_vld_o |-> (($countones(code_o[a*CODE_W +: CODE_W]) >= 4) &&
                      ($countones(code_o[a*CODE_W +: CODE_W]) <= 6)));
  end

  assert_rd_heavy_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (code_vld_o && ($countones(code_o[CW-1 -: CODE_W]) == 6)) |-> rd_o);
  assert_rd_light_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (code_vld_o && ($countones(code_o[CW-1 -: CODE_W]) == 4)) |-> !rd_o);
endmodule

// File: tb/tb_lc8b10b_enc.sv
module tb_lc8b10b_enc;
  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  // two-lane copy
  logic        v2, fe2, fr2;
  logic [15:0] d2;
  logic [1:0]  c2, kerr2;
  logic [19:0] code2;
  logic        vld2, rd2;
  // one-lane copy
  logic        v1, fe1, fr1, c1;
  logic [7:0]  d1;
  logic [0:0]  kerr1;
  logic [9:0]  code1;
  logic        vld1, rd1;

  lc8b10b_enc #(.LANES(2), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_n_i(rst_n), .valid_i(v2), .data_i(d2), .ctl_i(c2),
    .force_en_i(fe2), .force_rd_i(fr2), .code_o(code2), .code_vld_o(vld2),
    .kerr_o(kerr2), .rd_o(rd2));

  lc8b10b_enc #(.LANES(1), .SYNC_STAGES(2)) dut_s (
    .clk_i(clk), .rst_n_i(rst_n), .valid_i(v1), .data_i(d1), .ctl_i(c1),
    .force_en_i(fe1), .force_rd_i(fr1), .code_o(code1), .code_vld_o(vld1),
    .kerr_o(kerr1), .rd_o(rd1));

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {ctl, byte, start rd, code abcdeifghj, end rd, kerr}
  localparam logic [21:0] VEC [16] = '{
    {1'b1, 8'hBC, 1'b0, 10'b0011111010, 1'b1, 1'b0},  // R2 K28.5-
    {1'b1, 8'hBC, 1'b1, 10'b1100000101, 1'b0, 1'b0},  // R2 K28.5+
    {1'b0, 8'h00, 1'b0, 10'b1001110100, 1'b0, 1'b0},  // R1 D0.0-
    {1'b0, 8'h00, 1'b1, 10'b0110001011, 1'b1, 1'b0},  // R1 D0.0+
    {1'b0, 8'hB5, 1'b0, 10'b1010101010, 1'b0, 1'b0},  // R1 D21.5
    {1'b0, 8'h07, 1'b1, 10'b0001110100, 1'b0, 1'b0},  // R1 D7.0+
    {1'b0, 8'hF1, 1'b0, 10'b1000110111, 1'b1, 1'b0},  // R5 D17.7- alternate
    {1'b0, 8'hEB, 1'b1, 10'b1101001000, 1'b0, 1'b0},  // R5 D11.7+ alternate
    {1'b0, 8'hEB, 1'b0, 10'b1101001110, 1'b1, 1'b0},  // R5 D11.7- primary
    {1'b1, 8'h3C, 1'b0, 10'b0011111001, 1'b1, 1'b0},  // R2 K28.1-
    {1'b1, 8'hFC, 1'b0, 10'b0011111000, 1'b0, 1'b0},  // R2 K28.7-
    {1'b1, 8'hF7, 1'b0, 10'b1110101000, 1'b0, 1'b0},  // R2 K23.7-
    {1'b0, 8'h4A, 1'b0, 10'b0101010101, 1'b0, 1'b0},  // R1 D10.2
    {1'b0, 8'h7F, 1'b0, 10'b1010110011, 1'b1, 1'b0},  // R1 D31.3-
    {1'b1, 8'h00, 1'b0, 10'b1001110100, 1'b0, 1'b1},  // R6 illegal control
    {1'b1, 8'hFC, 1'b1, 10'b1100000111, 1'b1, 1'b0}   // R2 K28.7+
  };

  // inputs are applied after a falling edge; results sampled at the next falling edge
  task automatic send1(input logic ctl, input logic [7:0] b, input logic fe, input logic fr);
    v1 = 1'b1; c1 = ctl; d1 = b; fe1 = fe; fr1 = fr;
    @(negedge clk);
    v1 = 1'b0; fe1 = 1'b0;
  endtask

  task automatic send2(input logic [1:0] ctl, input logic [15:0] b, input logic fe, input logic fr);
    v2 = 1'b1; c2 = ctl; d2 = b; fe2 = fe; fr2 = fr;
    @(negedge clk);
    v2 = 1'b0; fe2 = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    v1 = 0; fe1 = 0; fr1 = 0; c1 = 0; d1 = 0;
    v2 = 0; fe2 = 0; fr2 = 0; c2 = 0; d2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 reset state
    chk("R4 code2", {12'd0, code2}, 32'd0);
    chk("R4 vld2", {31'd0, vld2}, 32'd0);
    chk("R4 kerr2", {30'd0, kerr2}, 32'd0);
    chk("R4 rd2", {31'd0, rd2}, 32'd0);
    chk("R4 rd1", {31'd0, rd1}, 32'd0);

    // R7 two lanes chained from the negative reset disparity
    send2(2'b11, 16'hBCBC, 1'b0, 1'b0);
    chk("R7 code2", {12'd0, code2}, {12'd0, 10'b1100000101, 10'b0011111010});
    chk("R7 rd2", {31'd0, rd2}, 32'd0);
    chk("R9 vld2 high", {31'd0, vld2}, 32'd1);
    @(negedge clk);
    chk("R9 vld2 low", {31'd0, vld2}, 32'd0);

    // R8 force positive on lane 0; D0.0 then D21.5
    send2(2'b00, 16'hB500, 1'b1, 1'b1);
    chk("R8 code2", {12'd0, code2}, {12'd0, 10'b1010101010, 10'b0110001011});
    chk("R8 rd2", {31'd0, rd2}, 32'd1);

    // R7 upper lane starts from lower lane's ending disparity
    send2(2'b10, 16'hBC00, 1'b0, 1'b0);
    chk("R7 chain code2", {12'd0, code2}, {12'd0, 10'b1100000101, 10'b0110001011});
    chk("R7 chain rd2", {31'd0, rd2}, 32'd0);

    // R6 illegal control flag on the upper lane only
    send2(2'b10, 16'h00BC, 1'b0, 1'b0);
    chk("R6 kerr2", {30'd0, kerr2}, 32'd2);

    // R3 running disparity carried between cycles on one lane
    send1(1'b1, 8'hBC, 1'b0, 1'b0);
    chk("R3 first code1", {22'd0, code1}, {22'd0, 10'b0011111010});
    chk("R3 first rd1", {31'd0, rd1}, 32'd1);
    send1(1'b1, 8'hBC, 1'b0, 1'b0);
    chk("R3 second code1", {22'd0, code1}, {22'd0, 10'b1100000101});
    chk("R3 second rd1", {31'd0, rd1}, 32'd0);

    // R10 idle cycle with force asserted changes nothing
    v1 = 1'b0; fe1 = 1'b1; fr1 = 1'b1; c1 = 1'b0; d1 = 8'h00;
    @(negedge clk);
    fe1 = 1'b0;
    chk("R10 vld1", {31'd0, vld1}, 32'd0);
    chk("R10 code1", {22'd0, code1}, {22'd0, 10'b1100000101});
    chk("R10 rd1", {31'd0, rd1}, 32'd0);

    // table: R1 R2 R5 R6 with R8 forcing each row's start disparity
    for (int i = 0; i < 16; i++) begin
      send1(VEC[i][21], VEC[i][20:13], 1'b1, VEC[i][12]);
      chk($sformatf("R1 R2 R5 vector %0d code", i), {22'd0, code1}, {22'd0, VEC[i][11:2]});
      chk($sformatf("R3 R8 vector %0d rd", i), {31'd0, rd1}, {31'd0, VEC[i][1]});
      chk($sformatf("R6 vector %0d kerr", i), {31'd0, kerr1}, {31'd0, VEC[i][0]});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule